// File: doc/BRIEF.md
# Serial Register Port with Shared Ready Pin

This block is the host-side serial port of a data converter. A host drives an active-low select, a serial clock that idles high, and a data input. The block returns a single output pin that does two jobs. While a read is shifting out, the pin carries register bits. At all other times it shows an active-low ready flag that tells the host a fresh 24-bit conversion result is waiting. All port inputs are synchronised into the system clock and their edges are detected there, so the whole port lives in one clock domain.

Every transfer starts with an 8-bit command byte. Its address field picks the register, and one bit picks read or write. The converter side pulses a completion strobe with each new offset-binary result. Shortly before it writes the next result, it also pulses an early-warning strobe. A synchronisation input parks the ready flag high without touching the serial logic. The select may be tied low for 3-wire use, since each frame ends after a known number of bits.

Top module: `serial_ready_port`

## Requirements
- R1: After reset the control word is zero and the ready flag reads high.
- R2: The port changes a read data bit only after a falling serial clock edge, so the host samples it on the next rising edge. Bits leave MSB first.
- R3: A completion strobe while sync is high stores the result and pulls the ready flag low. The pin shows the flag whenever select is low and no read bit is being driven.
- R4: The early-warning strobe returns an unread ready flag to high. The stored result stays readable.
- R5: While sync is low, the ready flag is held high and completion strobes are ignored. A frame in progress completes correctly.
- R6: Command byte layout: bit 6 set means read and bit 6 clear means write. Bits 5:0 are the address and bit 7 is not decoded. Address 0x01 is the 16-bit control word. Address 0x02 is the 24-bit result, which is read-only. Address 0x05 is an 8-bit read-only identity. Any other address is 8 bits wide, reads as zero and ignores writes.
- R7: A control write, sent MSB first, appears on `ctrl_word` at the end of the frame and reads back unchanged.
- R8: A result read returns the stored 24-bit word. The ready flag goes high once its last bit has been clocked.
- R9: While select is high, the output enable is low and the frame logic returns to the command phase. A partial frame is discarded.
- R10: A result read copies the word when the command completes. A result that arrives during the read does not change the shifted word, and the ready flag stays low after that read.
- R11: With select held low, consecutive frames run back to back.
- R12: Writes to the result, the identity or an unused address leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low port select |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in |
| dout | output | 1 | Read data or active-low ready flag |
| dout_oe | output | 1 | Output enable for the shared pin |
| sync_n | input | 1 | Active-low synchronisation hold |
| conv_valid | input | 1 | One-cycle strobe: new result on conv_data |
| conv_data | input | RES_W | Offset-binary conversion result |
| pre_update | input | 1 | One-cycle strobe ahead of the next result write |
| ctrl_word | output | CTRL_W | Current control register contents |

## Verification
The bench builds the block with RES_W=24, CTRL_W=16 and two synchroniser stages, and overrides ID_VALUE to 0x5A so that the identity read shows the parameter reaching the shift path. The serial clock runs at eight system cycles per half period. This leaves room for the synchroniser and edge-detect latency before each sample, and it lets strobes be placed between specific serial edges. That timing makes the mid-read result arrival, a sync pulse inside a frame and an abort partway through a command byte all reachable in a controlled way.

// File: rtl/srdy_pkg.sv
package srdy_pkg;

    localparam int CMD_W = 8;
    localparam int LEN_W = 6;

    localparam logic [5:0] ADR_CTRL = 6'h01;
    localparam logic [5:0] ADR_DATA = 6'h02;
    localparam logic [5:0] ADR_ID   = 6'h05;

    typedef enum logic [1:0] {
        PH_CMD = 2'd0,
        PH_WR  = 2'd1,
        PH_RD  = 2'd2
    } phase_e;

    typedef struct packed {
        logic       spare;
        logic       rd;
        logic [5:0] addr;
    } cmd_t;

    // Number of data bits that follow a command for a given address
    function automatic logic [LEN_W-1:0] len_of(input logic [5:0] a,
                                                input int res_w,
                                                input int ctrl_w);
        case (a)
            ADR_CTRL: return LEN_W'(ctrl_w);
            ADR_DATA: return LEN_W'(res_w);
            default:  return LEN_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/srdy_sync.sv
module srdy_sync #(
    parameter int             W      = 3,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] q_d;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{INIT[b]}};
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) q_d <= INIT;
        else     q_d <= q;
    end

    assign rise = q & ~q_d;
    assign fall = ~q & q_d;
endmodule

// File: rtl/srdy_frame.sv
module srdy_frame
    import srdy_pkg::*;
#(
    parameter int RES_W  = 24,
    parameter int CTRL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_act,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             sdi,
    input  logic [RES_W-1:0] rd_word,
    output logic [5:0]       peek_addr,
    output logic [5:0]       cur_addr,
    output logic             drv,
    output logic             dout_bit,
    output logic             wr_stb,
    output logic [RES_W-1:0] wr_data,
    output logic             rd_start,
    output logic             rd_done
);
    logic [RES_W-1:0] in_sr, out_sr;
    logic [LEN_W-1:0] cnt, len;
    phase_e           phase;
    cmd_t             nxt_cmd;

    assign nxt_cmd   = cmd_t'({in_sr[CMD_W-2:0], sdi});
    assign peek_addr = nxt_cmd.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sr    <= '0;
            out_sr   <= '0;
            cnt      <= '0;
            len      <= '0;
            phase    <= PH_CMD;
            cur_addr <= '0;
            drv      <= 1'b0;
            dout_bit <= 1'b0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
            rd_start <= 1'b0;
            rd_done  <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            rd_start <= 1'b0;
            rd_done  <= 1'b0;
            if (!sel_act) begin
                phase <= PH_CMD;
                cnt   <= '0;
                drv   <= 1'b0;
            end else begin
                if (sck_rise) begin
                    in_sr <= {in_sr[RES_W-2:0], sdi};
                    if (phase == PH_CMD) begin
                        if (cnt == LEN_W'(CMD_W - 1)) begin
                            cnt      <= '0;
                            cur_addr <= nxt_cmd.addr;
                            len      <= len_of(nxt_cmd.addr, RES_W, CTRL_W);
                            if (nxt_cmd.rd) begin
                                phase    <= PH_RD;
                                out_sr   <= rd_word;
                                rd_start <= 1'b1;
                            end else begin
                                phase <= PH_WR;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else if (cnt == len - 1'b1) begin
                        cnt   <= '0;
                        phase <= PH_CMD;
                        drv   <= 1'b0;
                        if (phase == PH_RD) begin
                            rd_done <= 1'b1;
                        end else begin
                            wr_stb  <= 1'b1;
                            wr_data <= {in_sr[RES_W-2:0], sdi};
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                if (sck_fall && phase == PH_RD) begin
                    dout_bit <= out_sr[RES_W-1];
                    out_sr   <= out_sr << 1;
                    drv      <= 1'b1;
                end
            end
        end
    end

    // R9
    sel_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_act |=> (phase == PH_CMD && cnt == '0 && !drv));

    // R2
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sck_fall |=> $stable(dout_bit));
endmodule

// File: rtl/srdy_ready.sv
module srdy_ready (
    input  logic clk,
    input  logic rst,
    input  logic sync_n,
    input  logic conv_valid,
    input  logic pre_update,
    input  logic rd_start,
    input  logic rd_done,
    output logic rdy_n
);
    logic fresh;

    always_ff @(posedge clk) begin
        if (rst || !sync_n) begin
            rdy_n <= 1'b1;
            fresh <= 1'b0;
        end else begin
            if (rd_start) fresh <= 1'b0;
            if (conv_valid) begin
                rdy_n <= 1'b0;
                fresh <= 1'b1;
            end else if (pre_update) begin
                rdy_n <= 1'b1;
            end else if (rd_done && !fresh) begin
                rdy_n <= 1'b1;
            end
        end
    end

    // R5
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sync_n |=> rdy_n);

    // R3
    conv_low_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_valid && sync_n) |=> !rdy_n);
endmodule

// File: rtl/serial_ready_port.sv
module serial_ready_port
    import srdy_pkg::*;
#(
    parameter int         RES_W       = 24,
    parameter int         CTRL_W      = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ID_VALUE    = 8'h4C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              dout,
    output logic              dout_oe,
    input  logic              sync_n,
    input  logic              conv_valid,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              pre_update,
    output logic [CTRL_W-1:0] ctrl_word
);
    // Registers are left-justified in a RES_W wide shift word
    localparam int CTRL_PAD = RES_W - CTRL_W;
    localparam int ID_PAD   = RES_W - 8;

    logic [2:0]        s_q, s_rise, s_fall;
    logic              sel_act;
    logic [5:0]        peek_addr, cur_addr;
    logic              drv, dout_bit, wr_stb, rd_start, rd_done, rdy_n;
    logic [RES_W-1:0]  wr_data, rd_word, result_q;
    logic [CTRL_W-1:0] ctrl_q;

    srdy_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b011)) u_sync (
        .clk(clk), .rst(rst), .d({sdi, sel_n, sclk}),
        .q(s_q), .rise(s_rise), .fall(s_fall)
    );

    assign sel_act = ~s_q[1];

    always_comb begin
        case (peek_addr)
            ADR_CTRL: rd_word = RES_W'(ctrl_q) << CTRL_PAD;
            ADR_DATA: rd_word = result_q;
            ADR_ID:   rd_word = RES_W'(ID_VALUE) << ID_PAD;
            default:  rd_word = '0;
        endcase
    end

    srdy_frame #(.RES_W(RES_W), .CTRL_W(CTRL_W)) u_frame (
        .clk(clk), .rst(rst), .sel_act(sel_act),
        .sck_rise(s_rise[0]), .sck_fall(s_fall[0]), .sdi(s_q[2]),
        .rd_word(rd_word), .peek_addr(peek_addr), .cur_addr(cur_addr),
        .drv(drv), .dout_bit(dout_bit), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_start(rd_start), .rd_done(rd_done)
    );

    srdy_ready u_ready (
        .clk(clk), .rst(rst), .sync_n(sync_n),
        .conv_valid(conv_valid), .pre_update(pre_update),
        .rd_start(rd_start && cur_addr == ADR_DATA),
        .rd_done(rd_done && cur_addr == ADR_DATA),
        .rdy_n(rdy_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            result_q <= '0;
        end else begin
            if (wr_stb && cur_addr == ADR_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
            if (conv_valid && sync_n)           result_q <= conv_data;
        end
    end

    assign ctrl_word = ctrl_q;
    assign dout_oe   = sel_act;
    assign dout      = drv ? dout_bit : rdy_n;

    // R12
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && cur_addr != ADR_CTRL) |=> $stable(ctrl_q));
endmodule

// File: tb/sim_serial_ready_port.sv
module sim_serial_ready_port;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
    logic        sync_n = 1'b1, conv_valid = 1'b0, pre_update = 1'b0;
    logic [23:0] conv_data = '0;
    logic        dout, dout_oe;
    logic [15:0] ctrl_word;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    serial_ready_port #(.ID_VALUE(8'h5A)) u0 (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
        .dout(dout), .dout_oe(dout_oe), .sync_n(sync_n),
        .conv_valid(conv_valid), .conv_data(conv_data),
        .pre_update(pre_update), .ctrl_word(ctrl_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic r);
        sclk = 1'b0; sdi = b;
        wait_cyc(HALF);
        r = dout;
        sclk = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic open_sel();
        if (sel_n) begin sel_n = 1'b0; wait_cyc(4); end
    endtask

    task automatic send_cmd(input logic [7:0] cmd);
        logic r;
        open_sel();
        for (int i = 7; i >= 0; i--) bit_io(cmd[i], r);
    endtask

    task automatic data_bits(input int n, input logic [23:0] wd, output logic [23:0] rd);
        logic r;
        rd = '0;
        for (int i = n - 1; i >= 0; i--) begin
            bit_io(wd[i], r);
            rd = {rd[22:0], r};
        end
    endtask

    task automatic xfer(input logic [7:0] cmd, input int n, input logic [23:0] wd,
                        output logic [23:0] rd, input bit keep);
        send_cmd(cmd);
        data_bits(n, wd, rd);
        if (!keep) begin sel_n = 1'b1; wait_cyc(4); end
    endtask

    task automatic conv(input logic [23:0] v);
        conv_data = v; conv_valid = 1'b1;
        wait_cyc(1);
        conv_valid = 1'b0;
        wait_cyc(3);
    endtask

    task automatic t_reset();
        chk("R9 oe low while deselected", dout_oe, 0);
        chk("R1 ctrl zero after reset", ctrl_word, 0);
        open_sel();
        chk("R1 ready high after reset", dout, 1);
        chk("R9 oe high when selected", dout_oe, 1);
        sel_n = 1'b1; wait_cyc(4);
    endtask

    task automatic t_ctrl();
        logic [23:0] rd;
        xfer(8'h01, 16, 24'h00A5C3, rd, 0);
        chk("R7 ctrl_word after write", ctrl_word, 16'hA5C3);
        xfer(8'h41, 16, 0, rd, 0);
        chk("R7 ctrl readback", rd[15:0], 16'hA5C3);
        xfer(8'hC1, 16, 0, rd, 0);
        chk("R6 bit7 ignored on read", rd[15:0], 16'hA5C3);
        xfer(8'h45, 8, 0, rd, 0);
        chk("R6 identity read", rd[7:0], 8'h5A);
        xfer(8'h47, 8, 0, rd, 0);
        chk("R6 unused address reads zero", rd[7:0], 8'h00);
    endtask

    task automatic t_result();
        logic [23:0] rd;
        open_sel();
        conv(24'h123456);
        chk("R3 ready low after result", dout, 0);
        xfer(8'h42, 24, 0, rd, 1);
        chk("R8 result word MSB first", rd, 24'h123456);
        chk("R8 ready high after last bit", dout, 1);
        conv(24'h800001);
        xfer(8'h42, 24, 0, rd, 1);
        chk("R2 bit alignment offset-binary", rd, 24'h800001);
        sel_n = 1'b1; wait_cyc(4);
    endtask

    task automatic t_preupdate();
        logic [23:0] rd;
        open_sel();
        conv(24'h0F0F0F);
        chk("R3 ready low before warning", dout, 0);
        pre_update = 1'b1; wait_cyc(1); pre_update = 1'b0; wait_cyc(3);
        chk("R4 ready high after warning", dout, 1);
        xfer(8'h42, 24, 0, rd, 0);
        chk("R4 result still readable", rd, 24'h0F0F0F);
    endtask

    task automatic t_sync();
        logic [23:0] rd;
        open_sel();
        conv(24'hABCDEF);
        sync_n = 1'b0; wait_cyc(2);
        chk("R5 ready high while sync low", dout, 1);
        conv(24'h111111);
        chk("R5 ready held high during strobe", dout, 1);
        sync_n = 1'b1; wait_cyc(3);
        chk("R5 ready still high after sync", dout, 1);
        xfer(8'h42, 24, 0, rd, 0);
        chk("R5 strobe ignored during sync", rd, 24'hABCDEF);
        send_cmd(8'h41);
        sync_n = 1'b0; wait_cyc(3); sync_n = 1'b1;
        data_bits(16, 0, rd);
        sel_n = 1'b1; wait_cyc(4);
        chk("R5 frame undisturbed by sync", rd[15:0], 16'hA5C3);
    endtask

    task automatic t_midread();
        logic [23:0] rd;
        open_sel();
        conv(24'h00AAAA);
        send_cmd(8'h42);
        data_bits(5, 0, rd);
        conv(24'h00BBBB);
        begin
            logic [23:0] rest;
            data_bits(19, 0, rest);
            rd = {rd[4:0], rest[18:0]};
        end
        chk("R10 snapshot word", rd, 24'h00AAAA);
        chk("R10 ready low after read", dout, 0);
        xfer(8'h42, 24, 0, rd, 0);
        chk("R10 new word on next read", rd, 24'h00BBBB);
    endtask

    task automatic t_abort();
        logic [23:0] rd;
        logic r;
        open_sel();
        bit_io(1'b1, r); bit_io(1'b1, r); bit_io(1'b0, r);
        sel_n = 1'b1; wait_cyc(4);
        chk("R9 oe released on deselect", dout_oe, 0);
        xfer(8'h45, 8, 0, rd, 0);
        chk("R9 frame realigned after abort", rd[7:0], 8'h5A);
    endtask

    task automatic t_3wire();
        logic [23:0] rd;
        open_sel();
        xfer(8'h01, 16, 24'h003C96, rd, 1);
        xfer(8'h41, 16, 0, rd, 1);
        chk("R11 back-to-back readback", rd[15:0], 16'h3C96);
        xfer(8'h45, 8, 0, rd, 1);
        chk("R11 third frame", rd[7:0], 8'h5A);
        sel_n = 1'b1; wait_cyc(4);
    endtask

    task automatic t_ro_write();
        logic [23:0] rd;
        conv(24'h765432);
        xfer(8'h02, 24, 24'hFFFFFF, rd, 0);
        xfer(8'h3F, 8, 24'h0000FF, rd, 0);
        xfer(8'h05, 8, 24'h000000, rd, 0);
        chk("R12 ctrl unchanged", ctrl_word, 16'h3C96);
        xfer(8'h42, 24, 0, rd, 0);
        chk("R12 result unchanged", rd, 24'h765432);
        xfer(8'h45, 8, 0, rd, 0);
        chk("R12 identity unchanged", rd[7:0], 8'h5A);
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);
        t_reset();
        t_ctrl();
        t_result();
        t_preupdate();
        t_sync();
        t_midread();
        t_abort();
        t_3wire();
        t_ro_write();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule